// File: doc/BRIEF.md
# Transmit Phase Alignment Sequencer

This block runs the transmit phase-alignment handshake for a group of serial transceiver lanes. It runs in the user clock domain and issues a single sync request that fans out to every lane. Each lane reports its transmit PLL lock. The sequencer waits until every lane reports lock, and until that lock has held without a break for a programmable qualification time. It then asserts sync for a fixed alignment window, waits a short gap, and drives a timed transmit-reset pulse. At that point it reports done.

Any loss of lock on any lane aborts the sequence. The sequencer returns to idle, and a new run starts from the qualification step once lock returns. After a completed sequence, a one-cycle start request reruns the alignment without waiting for a new lock edge. All pins are plain control and status levels, so there is no streaming interface and no back-pressure. Every interval is a parameter in user-clock cycles. The sync hold must be sized to cover at least 64 cycles of the alignment reference clock.

Top module: `txalign_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sync_out`, `txrst_out`, `done` and `busy` are all 0.
- R2: While any bit of `lock_in` is 0, `sync_out` and `busy` remain 0.
- R3: When all bits of `lock_in` rise together and stay high, `busy` is 1 after the 3rd rising edge. `sync_out` first reads 1 after edge QUAL_CYCLES+3. That count is two synchronizer stages, QUAL_CYCLES counting cycles and one state step.
- R4: Any low sample of lock during qualification clears the stability count. The QUAL_CYCLES+3 latency is then measured from the last rise of lock.
- R5: `sync_out` stays high for exactly SYNC_HOLD cycles. A `start_req` pulse during this window does not change its length.
- R6: After `sync_out` falls, both `sync_out` and `txrst_out` stay 0 for exactly GAP_CYCLES cycles.
- R7: `txrst_out` is then high for exactly RST_CYCLES cycles.
- R8: `done` goes to 1 on the cycle after `txrst_out` falls. At that point `busy` is 0. `done` stays 1 while lock stays high and no start request arrives.
- R9: If any lane drops lock during qualification, sync, gap or reset, `sync_out`, `txrst_out` and `busy` still hold on the 2nd edge and are 0 after the 3rd edge.
- R10: If lock drops while `done` is 1, `done` clears after the 3rd edge. When lock returns, the full sequence runs again with the R3 latency.
- R11: A one-cycle `start_req` while `done` is 1 clears `done` and sets `busy` after the next edge. `sync_out` rises after the following edge, because the qualification is still met.
- R12: `sync_out` and `txrst_out` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_in | input | NUM_LANES | Per-lane transmit PLL lock, asynchronous |
| start_req | input | 1 | Rerun request, acted on only when done |
| sync_out | output | 1 | Phase-alignment sync request to all lanes |
| txrst_out | output | 1 | Transmit reset pulse to all lanes |
| done | output | 1 | Sequence completed and lock held |
| busy | output | 1 | Qualification, sync, gap or reset in progress |

## Verification
The first run raises lock on all lanes at once. It measures the lock-to-sync latency and the sync, gap and reset lengths against the parameters, which separates a correct sequence from one with an off-by-one in any stage. A second run holds one lane low for a long time, which shows whether the lock inputs are combined as an AND. A third run puts a one-cycle dip into lock during qualification, which shows whether the stability count truly restarts. Lock is then dropped inside sync, inside the reset pulse and after done, and `start_req` is pulsed both mid-sync and after done, which separates aborts and reruns from inputs that must be ignored.

// File: rtl/txalign_pkg.sv
package txalign_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_QUAL = 3'd1,
    ST_SYNC = 3'd2,
    ST_GAP  = 3'd3,
    ST_RST  = 3'd4,
    ST_DONE = 3'd5
  } seq_state_t;
endpackage

// File: rtl/lane_lock_sync.sv
module lane_lock_sync #(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LANES-1:0] lock_in,
  output logic                 lock_ok
);
  logic [NUM_LANES-1:0] meta_q;
  logic [NUM_LANES-1:0] stab_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= lock_in[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign lock_ok = &stab_q;
endmodule

// File: rtl/lock_qual_timer.sv
module lock_qual_timer #(
  parameter int QUAL_CYCLES = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_ok,
  output logic qual_met
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

  logic [QW-1:0] qcnt;

  always_ff @(posedge clk) begin
    if (rst || !lock_ok) qcnt <= '0;
    else if (qcnt != QMAX) qcnt <= qcnt + 1'b1;
  end

  assign qual_met = (qcnt == QMAX);

  // R4
  qual_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_ok |=> (qcnt == '0));
endmodule

// File: rtl/align_fsm.sv
module align_fsm
  import txalign_pkg::*;
#(
  parameter int SYNC_HOLD  = 64,
  parameter int GAP_CYCLES = 8,
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_ok,
  input  logic qual_met,
  input  logic start_req,
  output logic sync_out,
  output logic txrst_out,
  output logic done,
  output logic busy
);
  localparam int MAXA = (SYNC_HOLD > GAP_CYCLES) ? SYNC_HOLD : GAP_CYCLES;
  localparam int MAXLEN = (MAXA > RST_CYCLES) ? MAXA : RST_CYCLES;
  localparam int PW = $clog2(MAXLEN + 1);
  localparam logic [PW-1:0] SYNC_LAST = PW'(SYNC_HOLD - 1);
  localparam logic [PW-1:0] GAP_LAST  = PW'(GAP_CYCLES - 1);
  localparam logic [PW-1:0] RST_LAST  = PW'(RST_CYCLES - 1);

  seq_state_t state, nxt;
  logic [PW-1:0] pc;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (lock_ok) nxt = ST_QUAL;
      ST_QUAL: if (qual_met) nxt = ST_SYNC;
      ST_SYNC: if (pc == SYNC_LAST) nxt = ST_GAP;
      ST_GAP:  if (pc == GAP_LAST) nxt = ST_RST;
      ST_RST:  if (pc == RST_LAST) nxt = ST_DONE;
      ST_DONE: if (start_req) nxt = ST_QUAL;
      default: nxt = ST_IDLE;
    endcase
    if (state != ST_IDLE && !lock_ok) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pc    <= '0;
    end else begin
      state <= nxt;
      if (nxt != state || nxt == ST_IDLE || nxt == ST_QUAL || nxt == ST_DONE) pc <= '0;
      else pc <= pc + 1'b1;
    end
  end

  assign sync_out  = (state == ST_SYNC);
  assign txrst_out = (state == ST_RST);
  assign done      = (state == ST_DONE);
  assign busy      = (state == ST_QUAL) || (state == ST_SYNC) ||
                     (state == ST_GAP)  || (state == ST_RST);

  // R12
  excl_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sync_out && txrst_out));

  // R9
  lock_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && !lock_ok) |=> (state == ST_IDLE));

  // R3
  sync_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_out) |-> $past(qual_met));

  // R7
  rst_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(txrst_out) |-> ($past(state) == ST_GAP));

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
endmodule

// File: rtl/txalign_seq.sv
module txalign_seq #(
  parameter int NUM_LANES   = 4,
  parameter int QUAL_CYCLES = 12000,
  parameter int SYNC_HOLD   = 64,
  parameter int GAP_CYCLES  = 8,
  parameter int RST_CYCLES  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LANES-1:0] lock_in,
  input  logic                 start_req,
  output logic                 sync_out,
  output logic                 txrst_out,
  output logic                 done,
  output logic                 busy
);
  logic lock_ok;
  logic qual_met;

  lane_lock_sync #(.NUM_LANES(NUM_LANES)) u_sync (
    .clk(clk), .rst(rst), .lock_in(lock_in), .lock_ok(lock_ok)
  );

  lock_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .lock_ok(lock_ok), .qual_met(qual_met)
  );

  align_fsm #(
    .SYNC_HOLD(SYNC_HOLD), .GAP_CYCLES(GAP_CYCLES), .RST_CYCLES(RST_CYCLES)
  ) u_fsm (
    .clk(clk), .rst(rst), .lock_ok(lock_ok), .qual_met(qual_met),
    .start_req(start_req), .sync_out(sync_out), .txrst_out(txrst_out),
    .done(done), .busy(busy)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !(sync_out || txrst_out || done || busy));
endmodule

// File: tb/txalign_seq_tb.sv
module txalign_seq_tb;
  localparam int LANES = 2;
  localparam int QUAL  = 20;
  localparam int HOLD  = 64;
  localparam int GAP   = 5;
  localparam int RSTW  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES-1:0] lock_in = '0;
  logic start_req = 1'b0;
  logic sync_out, txrst_out, done, busy;

  always #2 clk = ~clk;

  txalign_seq #(
    .NUM_LANES(LANES), .QUAL_CYCLES(QUAL), .SYNC_HOLD(HOLD),
    .GAP_CYCLES(GAP), .RST_CYCLES(RSTW)
  ) u_dut (
    .clk(clk), .rst(rst), .lock_in(lock_in), .start_req(start_req),
    .sync_out(sync_out), .txrst_out(txrst_out), .done(done), .busy(busy)
  );

  int n_chk = 0;
  int n_err = 0;
  bit sb_on = 1'b1;
  string lat_tag = "R3";
  int q_lat[$];
  int q_sync[$];
  int q_gap[$];
  int q_rst[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sb_pop(input int kind, input int act);
    int e;
    string tag;
    case (kind)
      0: tag = lat_tag;
      1: tag = "R5";
      2: tag = "R6";
      default: tag = "R7";
    endcase
    e = -1;
    case (kind)
      0: if (q_lat.size() > 0) e = q_lat.pop_front();
      1: if (q_sync.size() > 0) e = q_sync.pop_front();
      2: if (q_gap.size() > 0) e = q_gap.pop_front();
      default: if (q_rst.size() > 0) e = q_rst.pop_front();
    endcase
    chk(act == e, tag, act, e);
  endtask

  // scoreboard monitor
  bit prev_all = 0, prev_sync = 0, prev_rst = 0;
  bit lat_run = 0, gap_run = 0;
  int lat_cnt = 0, sync_cnt = 0, gap_cnt = 0, rst_cnt = 0;

  always @(negedge clk) begin
    bit all;
    all = &lock_in;
    if (rst || !sb_on) begin
      lat_run = 0;
      gap_run = 0;
    end else begin
      if (all && !prev_all) begin lat_run = 1; lat_cnt = 0; end
      else if (lat_run) lat_cnt++;
      if (sync_out && !prev_sync) begin
        if (lat_run) begin sb_pop(0, lat_cnt); lat_run = 0; end
        sync_cnt = 0;
      end
      if (sync_out) sync_cnt++;
      if (!sync_out && prev_sync) begin sb_pop(1, sync_cnt); gap_run = 1; gap_cnt = 0; end
      if (gap_run && !sync_out && !txrst_out) gap_cnt++;
      if (txrst_out && !prev_rst) begin
        if (gap_run) sb_pop(2, gap_cnt);
        gap_run = 0;
        rst_cnt = 0;
      end
      if (txrst_out) rst_cnt++;
      if (!txrst_out && prev_rst) sb_pop(3, rst_cnt);
    end
    prev_all = all;
    prev_sync = sync_out;
    prev_rst = txrst_out;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_run(input bit with_lat);
    if (with_lat) q_lat.push_back(QUAL + 3);
    q_sync.push_back(HOLD);
    q_gap.push_back(GAP);
    q_rst.push_back(RSTW);
  endtask

  // what: 0 sync, 1 txrst, 2 done
  task automatic wait_for(input int what, input string req);
    int n;
    bit hit;
    n = 0;
    hit = 0;
    while (!hit && n < 5000) begin
      @(negedge clk);
      n++;
      hit = (what == 0) ? sync_out : (what == 1) ? txrst_out : done;
    end
    if (!hit) chk(0, req, 0, 1);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    step(4);
    @(negedge clk);
    chk(!sync_out && !txrst_out && !done && !busy, "R1", {sync_out, txrst_out, done, busy}, 0);
    step(1);
    rst = 1'b0;
    step(1);
    @(negedge clk);
    chk(!sync_out && !txrst_out && !done && !busy, "R1", {sync_out, txrst_out, done, busy}, 0);

    // R2: one lane locked only
    step(1);
    lock_in = 2'b01;
    step(40);
    @(negedge clk);
    chk(!sync_out && !busy, "R2", {sync_out, busy}, 0);

    // R3/R5/R6/R7/R8: clean run
    step(1);
    expect_run(1);
    lock_in = 2'b11;
    step(3);
    @(negedge clk);
    chk(busy == 1'b1, "R3", busy, 1);
    wait_for(2, "R8");
    chk(done && !busy, "R8", {done, busy}, 2);
    step(50);
    @(negedge clk);
    chk(done && !sync_out && !txrst_out, "R8", {done, sync_out, txrst_out}, 4);

    // R10: lock loss in done
    step(1);
    lock_in = 2'b10;
    step(2);
    @(negedge clk);
    chk(done == 1'b1, "R10", done, 1);
    step(1);
    @(negedge clk);
    chk(!done && !busy, "R10", {done, busy}, 0);

    // R4: dip during qualification, plus start_req mid-sync (R11)
    step(1);
    lat_tag = "R4";
    expect_run(1);
    lock_in = 2'b11;
    step(10);
    lock_in = 2'b00;
    step(1);
    lock_in = 2'b11;
    wait_for(0, "R4");
    step(5);
    start_req = 1'b1;
    step(1);
    start_req = 1'b0;
    wait_for(2, "R11");
    chk(done == 1'b1, "R11", done, 1);

    // R11: rerun from done
    step(1);
    expect_run(0);
    start_req = 1'b1;
    step(1);
    start_req = 1'b0;
    @(negedge clk);
    chk(!done && busy, "R11", {done, busy}, 1);
    step(1);
    @(negedge clk);
    chk(sync_out == 1'b1, "R11", sync_out, 1);
    wait_for(2, "R11");

    // R9: aborts inside sync and inside reset
    step(1);
    sb_on = 1'b0;
    lock_in = 2'b00;
    step(4);
    lock_in = 2'b11;
    wait_for(0, "R9");
    step(1);
    lock_in = 2'b01;
    step(2);
    @(negedge clk);
    chk(sync_out == 1'b1, "R9", sync_out, 1);
    step(1);
    @(negedge clk);
    chk(!sync_out && !busy, "R9", {sync_out, busy}, 0);
    step(1);
    lock_in = 2'b11;
    wait_for(1, "R9");
    step(1);
    lock_in = 2'b10;
    step(3);
    @(negedge clk);
    chk(!txrst_out && !busy && !done, "R9", {txrst_out, busy, done}, 0);

    // R10: full rerun after regain
    step(1);
    sb_on = 1'b1;
    lat_tag = "R10";
    expect_run(1);
    lock_in = 2'b11;
    wait_for(2, "R10");
    step(2);
    chk(q_lat.size() + q_sync.size() + q_gap.size() + q_rst.size() == 0, "R3",
        q_lat.size() + q_sync.size() + q_gap.size() + q_rst.size(), 0);
    report();
    $finish;
  end
endmodule